// File: doc/BRIEF.md
# Two-Engine Blocked Integer Matrix Multiply-Accumulate

This block evaluates C = alpha·(A×B) + beta·C on signed integer matrices that live in memories beside it. A is m×k, B is k×n and C is m×n. A pulse on `start_i` latches m, n, k, alpha and beta. Each dimension may be any value from 1 to `MAXD`. The output is tiled into square sub-blocks of `LANES`×`LANES` elements. Two engines share the work, and each engine has `LANES` multiply-accumulate lanes. For one output row of a sub-block, each lane owns one column.

Engine e owns every row block whose index has parity e, and it writes only those rows of C. B is stored in two banks, split by block-column parity. The work runs in two stages. In stage 0, engine e reads bank e. Once both engines have finished stage 0, ownership of the banks is exchanged and each engine reads the other bank. This way every engine meets every block column of B exactly once. For each C row segment, the old C word is read once, the products are accumulated over k in a widened accumulator, and the scaled result is written back a single time. All memory read ports return data in the same cycle as the address.

Top module: `gemm_dual_top`

## Requirements
- R1: Every C element with row < m and column < n ends up holding the low `DATA_W` bits, in two's complement, of alpha·Σp A[row][p]·B[p][col] + beta·C_old[row][col], where the sum runs over p < k.
- R2: Any dimension from 1 to `MAXD` is accepted, and edge sub-blocks may be partial. A and B entries outside the m×k and k×n ranges have no effect, and C elements outside m×n are never written.
- R3: Each C element inside m×n is written exactly once per run. For a write, lane l of `c_we_o` is set exactly when column (block column·`LANES` + l) < n. No write occurs while the block is idle.
- R4: Engine e writes only rows r for which (r / `LANES`) mod 2 = e, so the two C ports never write the same word. The C word address is row·2^CBW + block column. Lane l of a C word holds column block·`LANES` + l.
- R5: A write to a block column whose parity equals the writing engine's index is a stage-0 write, and any other write is a stage-1 write. No stage-1 write happens before every stage-0 write of the run has been made. The bank swap happens only after both engines have finished stage 0.
- R6: When beta = 0, the old contents of C have no effect on the result.
- R7: A `start_i` pulse while a run is in progress is ignored. The run then continues with its latched sizes and scalars.
- R8: `done_o` is a single-cycle pulse, raised once per run only after all C writes of that run have been made. After reset, `done_o` is low and no write enable is set.
- R9: The A address for engine e is row·2^DW + column. B bank j holds the block columns of parity j. Its word address is p·2^QW + (block column / 2), and lane l of that word is column block·`LANES` + l. Bank j is driven by engine j in stage 0 and by engine 1−j in stage 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; latches sizes and scalars when idle |
| m_i | input | DIM_W | Row count of A and C |
| n_i | input | DIM_W | Column count of B and C |
| k_i | input | DIM_W | Inner dimension |
| alpha_i | input | DATA_W | Product scale, signed |
| beta_i | input | DATA_W | Old-C scale, signed |
| a_addr_o | output | 2×AAW | A read address, one per engine |
| a_rdata_i | input | 2×DATA_W | A read data, one per engine |
| b_addr_o | output | 2×BAW | B read address, one per bank |
| b_rdata_i | input | 2×LANES·DATA_W | B read word, one per bank |
| c_addr_o | output | 2×CAW | C word address, one per engine |
| c_rdata_i | input | 2×LANES·DATA_W | C read word, one per engine |
| c_we_o | output | 2×LANES | C per-lane write enables |
| c_wdata_o | output | 2×LANES·DATA_W | C write word |
| done_o | output | 1 | Run-complete pulse |

## Verification
The bench builds the block with `LANES`=4, `MAXD`=16 and `DATA_W`=16. With these values there are four block columns, two per B bank, so sizes of 5, 7, 13 or 3 leave partial edge blocks and n=4 leaves one bank with no work in stage 0. Full-range operands with large scalars push results well past 16 bits, which exercises the truncation. The small memories let the bench check every written word, the write order across the stage swap, and every untouched cell.

// File: rtl/gemm_pkg.sv
package gemm_pkg;
  typedef enum logic [2:0] {
    EN_IDLE,
    EN_CHK,
    EN_ROW,
    EN_MAC,
    EN_WB
  } en_state_e;
endpackage

// File: rtl/gemm_mac_lanes.sv
module gemm_mac_lanes #(
  parameter int LANES  = 12,
  parameter int DATA_W = 16,
  parameter int ACC_W  = 42
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      en_i,
  input  logic signed [DATA_W-1:0]  a_i,
  input  logic [LANES*DATA_W-1:0]   b_i,
  output logic [LANES*ACC_W-1:0]    acc_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [ACC_W-1:0] acc_q;
    logic signed [DATA_W-1:0] b_l;
    assign b_l = b_i[l*DATA_W +: DATA_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else if (en_i)  acc_q <= acc_q + ACC_W'(a_i) * ACC_W'(b_l);
    end
    assign acc_o[l*ACC_W +: ACC_W] = acc_q;
  end
endmodule

// File: rtl/gemm_engine.sv
module gemm_engine
  import gemm_pkg::*;
#(
  parameter int ENG    = 0,
  parameter int LANES  = 12,
  parameter int DATA_W = 16,
  parameter int DW     = 10,
  parameter int DIM_W  = 11,
  parameter int QW     = 6,
  parameter int ACC_W  = 42
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      go_i,
  input  logic                      stage_i,
  input  logic [DIM_W-1:0]          m_i,
  input  logic [DIM_W-1:0]          n_i,
  input  logic [DIM_W-1:0]          k_i,
  input  logic signed [DATA_W-1:0]  alpha_i,
  input  logic signed [DATA_W-1:0]  beta_i,
  output logic [2*DW-1:0]           a_addr_o,
  input  logic signed [DATA_W-1:0]  a_rdata_i,
  output logic [DW+QW-1:0]          b_addr_o,
  input  logic [LANES*DATA_W-1:0]   b_rdata_i,
  output logic [DW+QW:0]            c_addr_o,
  input  logic [LANES*DATA_W-1:0]   c_rdata_i,
  output logic [LANES-1:0]          c_we_o,
  output logic [LANES*DATA_W-1:0]   c_wdata_o,
  output logic                      fin_o
);
  localparam int RW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int CNT_W = DIM_W + $clog2(LANES + 1) + 1;
  localparam int SW    = ACC_W + DATA_W;
  localparam bit ENG_BIT = (ENG % 2) == 1;
  localparam logic [CNT_W-1:0] ROW0 = CNT_W'(ENG * LANES);

  en_state_e               st_q;
  logic                    bank_q, fin_q;
  logic [QW-1:0]           q_q;
  logic [CNT_W-1:0]        i_q, col_q;
  logic [RW-1:0]           r_q;
  logic [DIM_W-1:0]        p_q;
  logic [LANES*DATA_W-1:0] cbuf_q;
  logic [LANES*ACC_W-1:0]  acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= EN_IDLE; bank_q <= 1'b0; fin_q <= 1'b0; q_q <= '0;
      i_q <= '0; col_q <= '0; r_q <= '0; p_q <= '0; cbuf_q <= '0;
    end else if (go_i) begin
      st_q   <= EN_CHK;
      bank_q <= stage_i ^ ENG_BIT;
      col_q  <= (stage_i ^ ENG_BIT) ? CNT_W'(LANES) : '0;
      q_q    <= '0;
      i_q    <= ROW0;
      r_q    <= '0;
      fin_q  <= 1'b0;
    end else begin
      case (st_q)
        EN_CHK: begin
          if (col_q >= CNT_W'(n_i)) begin
            fin_q <= 1'b1;
            st_q  <= EN_IDLE;
          end else if (i_q >= CNT_W'(m_i)) begin
            // next block column held by the current bank
            q_q   <= q_q + 1'b1;
            col_q <= col_q + CNT_W'(2 * LANES);
            i_q   <= ROW0;
            r_q   <= '0;
          end else begin
            st_q <= EN_ROW;
          end
        end
        EN_ROW: begin
          cbuf_q <= c_rdata_i;
          p_q    <= '0;
          st_q   <= EN_MAC;
        end
        EN_MAC: begin
          if (p_q == k_i - DIM_W'(1)) st_q <= EN_WB;
          else p_q <= p_q + DIM_W'(1);
        end
        EN_WB: begin
          // skip the other engine's row block at a block boundary
          if (r_q == RW'(LANES - 1)) begin
            r_q <= '0;
            i_q <= i_q + CNT_W'(LANES + 1);
          end else begin
            r_q <= r_q + RW'(1);
            i_q <= i_q + CNT_W'(1);
          end
          st_q <= EN_CHK;
        end
        default: st_q <= EN_IDLE;
      endcase
    end
  end

  gemm_mac_lanes #(.LANES(LANES), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_lanes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q == EN_ROW),
    .en_i   (st_q == EN_MAC),
    .a_i    (a_rdata_i),
    .b_i    (b_rdata_i),
    .acc_o  (acc)
  );

  assign a_addr_o = {i_q[DW-1:0], p_q[DW-1:0]};
  assign b_addr_o = {p_q[DW-1:0], q_q};
  assign c_addr_o = {i_q[DW-1:0], q_q, bank_q};
  assign fin_o    = fin_q;

  for (genvar l = 0; l < LANES; l++) begin : g_wb
    logic signed [DATA_W-1:0] c_old;
    logic signed [ACC_W-1:0]  acc_l;
    assign c_old = cbuf_q[l*DATA_W +: DATA_W];
    assign acc_l = acc[l*ACC_W +: ACC_W];
    assign c_we_o[l] = (st_q == EN_WB) && ((col_q + CNT_W'(l)) < CNT_W'(n_i));
    assign c_wdata_o[l*DATA_W +: DATA_W] =
      DATA_W'(SW'(alpha_i) * SW'(acc_l) + SW'(beta_i) * SW'(c_old));
  end
endmodule

// File: rtl/gemm_stage_ctrl.sv
module gemm_stage_ctrl #(
  parameter int DATA_W = 16,
  parameter int DIM_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIM_W-1:0]  m_i,
  input  logic [DIM_W-1:0]  n_i,
  input  logic [DIM_W-1:0]  k_i,
  input  logic [DATA_W-1:0] alpha_i,
  input  logic [DATA_W-1:0] beta_i,
  input  logic [1:0]        fin_i,
  output logic [DIM_W-1:0]  m_o,
  output logic [DIM_W-1:0]  n_o,
  output logic [DIM_W-1:0]  k_o,
  output logic [DATA_W-1:0] alpha_o,
  output logic [DATA_W-1:0] beta_o,
  output logic              go_o,
  output logic              stage_o,
  output logic              busy_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_o <= '0; n_o <= '0; k_o <= '0; alpha_o <= '0; beta_o <= '0;
      go_o <= 1'b0; stage_o <= 1'b0; busy_o <= 1'b0; done_o <= 1'b0;
    end else begin
      go_o   <= 1'b0;
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          m_o <= m_i; n_o <= n_i; k_o <= k_i;
          alpha_o <= alpha_i; beta_o <= beta_i;
          busy_o  <= 1'b1;
          stage_o <= 1'b0;
          go_o    <= 1'b1;
        end
      end else if (!go_o && (&fin_i)) begin
        // barrier: both engines idle before the bank swap or finish
        if (!stage_o) begin
          stage_o <= 1'b1;
          go_o    <= 1'b1;
        end else begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gemm_dual_top.sv
module gemm_dual_top #(
  parameter int LANES  = 12,
  parameter int MAXD   = 1024,
  parameter int DATA_W = 16,
  localparam int DW    = $clog2(MAXD),
  localparam int DIM_W = DW + 1,
  localparam int NBLK  = (MAXD + LANES - 1) / LANES,
  localparam int NBH   = (NBLK + 1) / 2,
  localparam int QW    = (NBH > 1) ? $clog2(NBH) : 1,
  localparam int CBW   = QW + 1,
  localparam int AAW   = 2 * DW,
  localparam int BAW   = DW + QW,
  localparam int CAW   = DW + CBW,
  localparam int ROW_W = LANES * DATA_W,
  localparam int ACC_W = 2 * DATA_W + DW
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [DIM_W-1:0]           m_i,
  input  logic [DIM_W-1:0]           n_i,
  input  logic [DIM_W-1:0]           k_i,
  input  logic [DATA_W-1:0]          alpha_i,
  input  logic [DATA_W-1:0]          beta_i,
  output logic [1:0][AAW-1:0]        a_addr_o,
  input  logic [1:0][DATA_W-1:0]     a_rdata_i,
  output logic [1:0][BAW-1:0]        b_addr_o,
  input  logic [1:0][ROW_W-1:0]      b_rdata_i,
  output logic [1:0][CAW-1:0]        c_addr_o,
  input  logic [1:0][ROW_W-1:0]      c_rdata_i,
  output logic [1:0][LANES-1:0]      c_we_o,
  output logic [1:0][ROW_W-1:0]      c_wdata_o,
  output logic                       done_o
);
  logic [DIM_W-1:0]      m_q, n_q, k_q;
  logic [DATA_W-1:0]     alpha_q, beta_q;
  logic                  go, stage, busy;
  logic [1:0]            eng_fin;
  logic [1:0][BAW-1:0]   eng_b_addr;
  logic [1:0][ROW_W-1:0] eng_b_rdata;

  gemm_stage_ctrl #(.DATA_W(DATA_W), .DIM_W(DIM_W)) u_ctrl (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i),
    .m_i (m_i), .n_i (n_i), .k_i (k_i), .alpha_i (alpha_i), .beta_i (beta_i),
    .fin_i (eng_fin),
    .m_o (m_q), .n_o (n_q), .k_o (k_q), .alpha_o (alpha_q), .beta_o (beta_q),
    .go_o (go), .stage_o (stage), .busy_o (busy), .done_o (done_o)
  );

  for (genvar e = 0; e < 2; e++) begin : g_eng
    // bank e is owned by engine e in stage 0, by the other engine in stage 1
    assign b_addr_o[e]    = stage ? eng_b_addr[1-e] : eng_b_addr[e];
    assign eng_b_rdata[e] = stage ? b_rdata_i[1-e]  : b_rdata_i[e];

    gemm_engine #(
      .ENG (e), .LANES (LANES), .DATA_W (DATA_W), .DW (DW),
      .DIM_W (DIM_W), .QW (QW), .ACC_W (ACC_W)
    ) u_eng (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .go_i      (go),
      .stage_i   (stage),
      .m_i       (m_q),
      .n_i       (n_q),
      .k_i       (k_q),
      .alpha_i   (alpha_q),
      .beta_i    (beta_q),
      .a_addr_o  (a_addr_o[e]),
      .a_rdata_i (a_rdata_i[e]),
      .b_addr_o  (eng_b_addr[e]),
      .b_rdata_i (eng_b_rdata[e]),
      .c_addr_o  (c_addr_o[e]),
      .c_rdata_i (c_rdata_i[e]),
      .c_we_o    (c_we_o[e]),
      .c_wdata_o (c_wdata_o[e]),
      .fin_o     (eng_fin[e])
    );
  end
endmodule

// File: rtl/gemm_dual_chk.sv
module gemm_dual_chk #(
  parameter int LANES = 12,
  parameter int DIM_W = 11,
  parameter int CAW   = 17
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic                  done_i,
  input logic                  busy_i,
  input logic                  stage_i,
  input logic [1:0]            fin_i,
  input logic [1:0][LANES-1:0] c_we_i,
  input logic [1:0][CAW-1:0]   c_addr_i,
  input logic [DIM_W-1:0]      m_q_i
);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R8
  done_after_fin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(&fin_i));

  // R5
  swap_barrier_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stage_i) |-> $past(&fin_i));

  // R7
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> $stable(m_q_i));

  // R4
  no_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|c_we_i[0]) && (|c_we_i[1])) |-> (c_addr_i[0] != c_addr_i[1]));

  // R3
  we_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|c_we_i[0]) || (|c_we_i[1])) |-> busy_i);
endmodule

bind gemm_dual_top gemm_dual_chk #(.LANES(LANES), .DIM_W(DIM_W), .CAW(CAW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .done_i   (done_o),
  .busy_i   (busy),
  .stage_i  (stage),
  .fin_i    (eng_fin),
  .c_we_i   (c_we_o),
  .c_addr_i (c_addr_o),
  .m_q_i    (m_q)
);

// File: tb/gemm_dual_top_tb.sv
module gemm_dual_top_tb;
  localparam int L  = 4;
  localparam int MD = 16;
  localparam int DWD = 16;
  localparam int RW = L * DWD;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, done;
  logic [4:0] m, n, k;
  logic [15:0] alpha, beta;
  logic [1:0][7:0]    a_addr;
  logic [1:0][15:0]   a_rdata;
  logic [1:0][4:0]    b_addr;
  logic [1:0][RW-1:0] b_rdata;
  logic [1:0][5:0]    c_addr;
  logic [1:0][RW-1:0] c_rdata;
  logic [1:0][L-1:0]  c_we;
  logic [1:0][RW-1:0] c_wdata;

  gemm_dual_top #(.LANES(L), .MAXD(MD), .DATA_W(DWD)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .m_i (m), .n_i (n), .k_i (k), .alpha_i (alpha), .beta_i (beta),
    .a_addr_o (a_addr), .a_rdata_i (a_rdata),
    .b_addr_o (b_addr), .b_rdata_i (b_rdata),
    .c_addr_o (c_addr), .c_rdata_i (c_rdata),
    .c_we_o (c_we), .c_wdata_o (c_wdata), .done_o (done)
  );

  logic signed [15:0] amat [MD][MD];
  logic signed [15:0] bmat [MD][MD];
  logic signed [15:0] cmat [MD][MD];
  logic signed [15:0] corig[MD][MD];
  logic [15:0]        cref [MD][MD];
  bit                 wrote[MD][MD];

  int n_tests = 0, n_fail = 0;
  int cur_m = 0, cur_n = 0, s0_expected = 0, s0_done = 0, writes = 0, done_cnt = 0;
  bit done_seen = 0, prev_done = 0;
  int unsigned seed = 32'h1234_5678;

  // memory model, combinational read (R9 encodings)
  always_comb begin
    for (int e = 0; e < 2; e++) begin
      a_rdata[e] = amat[a_addr[e][7:4]][a_addr[e][3:0]];
      for (int l = 0; l < L; l++) begin
        b_rdata[e][l*16 +: 16] = bmat[b_addr[e][4:1]][(2*b_addr[e][0] + e)*L + l];
        c_rdata[e][l*16 +: 16] = cmat[c_addr[e][5:2]][c_addr[e][1:0]*L + l];
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(int lo, int hi);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return lo + int'((seed >> 8) % (hi - lo + 1));
  endfunction

  // per-clock comparison of every write against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check(!done, "R8 done width", done, 0);
      prev_done = done;
      if (done) begin
        check(writes == cur_m * cur_n, "R8 done after all writes", writes, cur_m * cur_n);
        done_cnt++;
        done_seen = 1;
      end
      for (int e = 0; e < 2; e++) begin
        if (|c_we[e]) begin
          int row, bj, stg, cnt;
          row = c_addr[e][5:2];
          bj  = c_addr[e][1:0];
          stg = (bj % 2) ^ e;
          check(((row / L) % 2) == e, "R4 row band", row, e);
          check(row < cur_m, "R2 row range", row, cur_m);
          if (stg == 1) check(s0_done == s0_expected, "R5 stage order", s0_done, s0_expected);
          cnt = 0;
          for (int l = 0; l < L; l++) begin
            int col;
            col = bj * L + l;
            check(c_we[e][l] == (col < cur_n), "R3 lane mask", c_we[e][l], col < cur_n);
            if (c_we[e][l]) begin
              cnt++;
              check(!wrote[row][col], "R3 single write", 1, 0);
              wrote[row][col] = 1;
              check(c_wdata[e][l*16 +: 16] == cref[row][col], "R1 R9 value",
                    $signed(c_wdata[e][l*16 +: 16]), $signed(cref[row][col]));
              cmat[row][col] = c_wdata[e][l*16 +: 16];
            end
          end
          writes += cnt;
          if (stg == 0) s0_done += cnt;
        end
      end
    end
  end

  task automatic run_case(int mm, int nn, int kk, int al, int be, int lo, int hi, bit poke);
    int cyc;
    for (int i = 0; i < MD; i++)
      for (int j = 0; j < MD; j++) begin
        amat[i][j] = 16'(rnd(lo, hi));
        bmat[i][j] = 16'(rnd(lo, hi));
        cmat[i][j] = 16'(rnd(lo, hi));
        corig[i][j] = cmat[i][j];
        wrote[i][j] = 0;
        cref[i][j] = '0;
      end
    s0_expected = 0;
    for (int i = 0; i < mm; i++)
      for (int j = 0; j < nn; j++) begin
        longint s, v;
        s = 0;
        for (int p = 0; p < kk; p++) s += longint'(amat[i][p]) * longint'(bmat[p][j]);
        v = longint'(al) * s + longint'(be) * longint'(corig[i][j]);
        cref[i][j] = 16'(v);
        if (((i / L) % 2) == ((j / L) % 2)) s0_expected++;
      end
    cur_m = mm; cur_n = nn; s0_done = 0; writes = 0; done_cnt = 0; done_seen = 0;
    @(negedge clk);
    m = 5'(mm); n = 5'(nn); k = 5'(kk); alpha = 16'(al); beta = 16'(be);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (15) @(negedge clk);
      m = 5'd1; n = 5'd1; k = 5'd1; alpha = '0; beta = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done_seen && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    check(done_seen, "R8 watchdog", cyc, 5000);
    repeat (4) @(negedge clk);
    check(done_cnt == 1, "R8 one done per run", done_cnt, 1);
    if (poke) check(writes == mm * nn, "R7 start ignored while busy", writes, mm * nn);
    for (int i = 0; i < MD; i++)
      for (int j = 0; j < MD; j++) begin
        if (i < mm && j < nn)
          check(cmat[i][j] == $signed(cref[i][j]), be == 0 ? "R6 final value" : "R1 final value",
                cmat[i][j], $signed(cref[i][j]));
        else
          check(cmat[i][j] == corig[i][j], "R2 untouched cell", cmat[i][j], corig[i][j]);
      end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    m = '0; n = '0; k = '0; alpha = '0; beta = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R8 reset done", done, 0);
    check(c_we == '0, "R8 reset write enables", c_we, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && c_we == '0, "R8 idle after reset", done, 0);
    run_case(8, 8, 8, 2, 3, -10, 10, 0);
    run_case(5, 7, 3, -1, 1, -10, 10, 0);
    run_case(16, 16, 16, 3, -2, -10, 10, 1);
    run_case(1, 1, 1, 1, 0, -30000, 30000, 0);
    run_case(13, 6, 11, 5, 0, -50, 50, 0);
    run_case(9, 16, 2, 1234, -777, -32768, 32767, 0);
    run_case(4, 4, 16, -3, 7, -100, 100, 0);
    run_case(16, 3, 1, 1, 1, -20, 20, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule